// File: doc/BRIEF.md
# Flash Command Decoder

This block is a synthesizable behavioural model of the command decoder in a parallel NOR flash device. The host issues bus write cycles that carry an address and a 16-bit data word. The low byte of each data word is decoded as an opcode, or is taken as operand data when a command sequence expects it. Reads are combinational. They return array contents, the 8-bit status byte, identifier codes or query-table bytes, according to a read mode that persists until another command changes it.

Programming uses a small internal array of `2**ADDR_W` words, and a cycle counter stands in for the busy time. A single-word program takes two write cycles. A buffered program takes a setup write, a count write, the data words and a confirm write. A factory-program mode, once entered, takes every later write as data until reset. While an operation is busy, only the status-read and suspend opcodes have any effect. A suspended program resumes on the confirm opcode.

Top module: `flash_cmd_ui`

## Requirements
- R1: After reset the status byte reads 0x80 (ready, no errors), the read mode is array, and every array word reads 0xFFFF.
- R2: A write of opcode 0xFF selects array reads, which return the addressed 16-bit word on all data bits.
- R3: A write of 0x70 selects status reads: bits [15:8] read 0, bit 7 is ready (0 while busy), bit 5 is the sequence/erase error, bit 4 is the program error, bit 2 is program-suspended, and the other bits read 0.
- R4: Opcode 0x90 selects identifier reads (address 0 gives MFR_CODE, address 1 gives DEV_CODE, other addresses give 0). Opcode 0x98 selects query reads (addresses 0x10, 0x11 and 0x12 give 0x51, 0x52 and 0x59, address 0x27 gives log2 of the array size in bytes, address 0x2A gives log2 of the buffer size in bytes, other addresses give 0). In both modes bits [15:8] read 0.
- R5: Opcode 0x50 clears both error bits and leaves the read mode as it was.
- R6: Opcode 0x40 followed by a data write switches to status reads and holds ready at 0 for exactly BUSY_CYCLES cycles. The addressed word then becomes its old value ANDed with the data.
- R7: While busy, writes other than 0x70 and 0xB0 are ignored. They change neither the error bits, nor the read mode, nor the array.
- R8: Opcode 0xB0 during a single-word program suspends it. Status then reads ready=1 and suspended=1, the array is unchanged, and 0xFF gives array reads. Opcode 0xD0 resumes the program in status mode, and the program then completes.
- R9: Opcode 0xE8, then a count write of N-1, then N address/data writes, then 0xD0, programs all N words. Ready stays 0 for BUSY_CYCLES+N cycles.
- R10: In a buffered program, a count above BUF_DEPTH-1 or a confirm write other than 0xD0 sets the program error bit and changes no array word.
- R11: Opcode 0x80 followed by 0xD0 enters factory mode with array reads. From then until reset, every write ANDs its data into the addressed word, and no opcode is decoded.
- R12: Opcode 0x80 followed by anything other than 0xD0 sets the sequence error bit and leaves the decoder ready for new commands.
- R13: An unrecognised opcode while ready sets the sequence error bit and selects array reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Bus write strobe, one cycle per write |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | 16 | Write data; opcodes sit in bits [7:0] |
| rdAddr | input | ADDR_W | Read address |
| rdData | output | 16 | Read data, selected by the current read mode |

## Verification
The program path is tried with three patterns. The first programs a fresh word. The second programs the same word again with overlapping zeros, which separates an AND-merge from a plain overwrite. The third is a three-word buffered burst, whose ready-low length separates per-word commit cycles from a single busy window. Writes issued during busy and during suspend use opcodes that would otherwise clear errors, change the mode or raise an error, so an ignored write can be told apart from a decoded one. The abort cases use an oversized count and a wrong confirm value, and each is followed by array reads of the targeted word. Factory mode is checked with data words that equal real opcodes, which shows whether decoding has stopped.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam logic [7:0] OP_READ_ARRAY = 8'hFF;
  localparam logic [7:0] OP_READ_STAT  = 8'h70;
  localparam logic [7:0] OP_READ_IDENT = 8'h90;
  localparam logic [7:0] OP_READ_QUERY = 8'h98;
  localparam logic [7:0] OP_CLEAR_ERR  = 8'h50;
  localparam logic [7:0] OP_WORD_PGM   = 8'h40;
  localparam logic [7:0] OP_BUF_PGM    = 8'hE8;
  localparam logic [7:0] OP_FACTORY    = 8'h80;
  localparam logic [7:0] OP_CONFIRM    = 8'hD0;
  localparam logic [7:0] OP_SUSPEND    = 8'hB0;

  typedef enum logic [1:0] {
    RM_ARRAY,
    RM_STATUS,
    RM_IDENT,
    RM_QUERY
  } readMode_t;

  typedef struct packed {
    logic latchWord;
    logic bufWrite;
    logic commitWord;
    logic commitBuf;
    logic directWrite;
    logic setPgmErr;
    logic setSeqErr;
    logic clrErr;
  } dpStrobe_t;

endpackage

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int BUF_DEPTH   = 512,
  parameter int BUSY_CYCLES = 8,
  localparam int CNT_W      = $clog2(BUF_DEPTH),
  localparam int TMR_W      = $clog2(BUSY_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [15:0]      wrData,
  output dpStrobe_t        stb,
  output logic [CNT_W-1:0] bufIdx,
  output readMode_t        readMode,
  output logic             ready,
  output logic             suspended
);

  typedef enum logic [3:0] {
    ST_IDLE, ST_PGM_SETUP, ST_BUF_COUNT, ST_BUF_DATA, ST_BUF_CONFIRM,
    ST_BUSY, ST_COMMIT, ST_SUSP, ST_FAC_SETUP, ST_FACTORY
  } ctrlState_t;

  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(BUSY_CYCLES - 1);

  ctrlState_t       state, nState;
  readMode_t        mode, nMode;
  logic [TMR_W-1:0] timer, nTimer;
  logic [CNT_W-1:0] count, nCount, idx, nIdx;
  logic             isBuf, nIsBuf;
  logic [7:0]       op;

  assign op        = wrData[7:0];
  assign bufIdx    = idx;
  assign readMode  = mode;
  assign ready     = !(state == ST_BUSY || state == ST_COMMIT);
  assign suspended = (state == ST_SUSP);

  always_comb begin
    stb    = '0;
    nState = state;
    nMode  = mode;
    nTimer = timer;
    nCount = count;
    nIdx   = idx;
    nIsBuf = isBuf;
    unique case (state)
      ST_IDLE: if (wrEn) begin
        case (op)
          OP_READ_ARRAY: nMode = RM_ARRAY;
          OP_READ_STAT:  nMode = RM_STATUS;
          OP_READ_IDENT: nMode = RM_IDENT;
          OP_READ_QUERY: nMode = RM_QUERY;
          OP_CLEAR_ERR:  stb.clrErr = 1'b1;
          OP_WORD_PGM:   begin nState = ST_PGM_SETUP; nMode = RM_STATUS; end
          OP_BUF_PGM:    begin nState = ST_BUF_COUNT; nMode = RM_STATUS; end
          OP_FACTORY:    begin nState = ST_FAC_SETUP; nMode = RM_STATUS; end
          default:       begin stb.setSeqErr = 1'b1; nMode = RM_ARRAY; end
        endcase
      end
      ST_PGM_SETUP: if (wrEn) begin
        stb.latchWord = 1'b1;
        nState = ST_BUSY;
        nTimer = '0;
        nIsBuf = 1'b0;
      end
      ST_BUF_COUNT: if (wrEn) begin
        if (int'(wrData) > BUF_DEPTH - 1) begin
          stb.setPgmErr = 1'b1;
          nState = ST_IDLE;
        end else begin
          nCount = wrData[CNT_W-1:0];
          nIdx   = '0;
          nState = ST_BUF_DATA;
        end
      end
      ST_BUF_DATA: if (wrEn) begin
        stb.bufWrite = 1'b1;
        if (idx == count) nState = ST_BUF_CONFIRM;
        else nIdx = idx + 1'b1;
      end
      ST_BUF_CONFIRM: if (wrEn) begin
        if (op == OP_CONFIRM) begin
          nState = ST_BUSY;
          nTimer = '0;
          nIdx   = '0;
          nIsBuf = 1'b1;
        end else begin
          stb.setPgmErr = 1'b1;
          nState = ST_IDLE;
        end
      end
      ST_BUSY: begin
        if (timer == TMR_LAST) begin
          nTimer = '0;
          if (isBuf) nState = ST_COMMIT;
          else begin
            stb.commitWord = 1'b1;
            nState = ST_IDLE;
          end
        end else begin
          nTimer = timer + 1'b1;
          if (wrEn && op == OP_READ_STAT) nMode = RM_STATUS;
          else if (wrEn && op == OP_SUSPEND && !isBuf) nState = ST_SUSP;
        end
      end
      ST_COMMIT: begin
        stb.commitBuf = 1'b1;
        if (idx == count) nState = ST_IDLE;
        else nIdx = idx + 1'b1;
      end
      ST_SUSP: if (wrEn) begin
        case (op)
          OP_CONFIRM:    begin nState = ST_BUSY; nMode = RM_STATUS; end
          OP_READ_STAT:  nMode = RM_STATUS;
          OP_READ_ARRAY: nMode = RM_ARRAY;
          default:       ;
        endcase
      end
      ST_FAC_SETUP: if (wrEn) begin
        if (op == OP_CONFIRM) begin
          nState = ST_FACTORY;
          nMode  = RM_ARRAY;
        end else begin
          stb.setSeqErr = 1'b1;
          nState = ST_IDLE;
        end
      end
      ST_FACTORY: if (wrEn) stb.directWrite = 1'b1;
      default: nState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      mode  <= RM_ARRAY;
      timer <= '0;
      count <= '0;
      idx   <= '0;
      isBuf <= 1'b0;
    end else begin
      state <= nState;
      mode  <= nMode;
      timer <= nTimer;
      count <= nCount;
      idx   <= nIdx;
      isBuf <= nIsBuf;
    end
  end

  // R8: a suspended program holds its elapsed time
  a_r8_susp_holds_timer: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SUSP) |=> $stable(timer));

  // R11: factory mode is left only through reset
  a_r11_factory_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FACTORY) |=> (state == ST_FACTORY && ready));

  // R9: the buffer commit walk never runs past the loaded count
  a_r9_commit_in_range: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_COMMIT) |-> (idx <= count));

endmodule

// File: rtl/flash_cmd_dpath.sv
module flash_cmd_dpath
  import flash_cmd_pkg::*;
#(
  parameter int         ADDR_W    = 6,
  parameter int         BUF_DEPTH = 512,
  parameter logic [7:0] MFR_CODE  = 8'hC3,
  parameter logic [7:0] DEV_CODE  = 8'h5E,
  localparam int        WORDS     = 1 << ADDR_W,
  localparam int        CNT_W     = $clog2(BUF_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [CNT_W-1:0]  bufIdx,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [15:0]       wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  input  readMode_t         readMode,
  input  logic              ready,
  input  logic              suspended,
  output logic [15:0]       rdData
);

  localparam logic [7:0] ARRAY_LOG = 8'($clog2(WORDS * 2));
  localparam logic [7:0] BUF_LOG   = 8'($clog2(BUF_DEPTH * 2));

  logic [15:0]       mem     [WORDS];
  logic [ADDR_W-1:0] bufAddr [BUF_DEPTH];
  logic [15:0]       bufData [BUF_DEPTH];
  logic [ADDR_W-1:0] holdAddr;
  logic [15:0]       holdData;
  logic              pgmErr, seqErr;
  logic [7:0]        statusByte, identByte, queryByte;

  always_ff @(posedge clk) begin
    if (stb.bufWrite) begin
      bufAddr[bufIdx] <= wrAddr;
      bufData[bufIdx] <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
      holdAddr <= '0;
      holdData <= '0;
      pgmErr   <= 1'b0;
      seqErr   <= 1'b0;
    end else begin
      if (stb.latchWord) begin
        holdAddr <= wrAddr;
        holdData <= wrData;
      end
      if (stb.commitWord) mem[holdAddr] <= mem[holdAddr] & holdData;
      else if (stb.commitBuf) mem[bufAddr[bufIdx]] <= mem[bufAddr[bufIdx]] & bufData[bufIdx];
      else if (stb.directWrite) mem[wrAddr] <= mem[wrAddr] & wrData;
      if (stb.clrErr) begin
        pgmErr <= 1'b0;
        seqErr <= 1'b0;
      end else begin
        if (stb.setPgmErr) pgmErr <= 1'b1;
        if (stb.setSeqErr) seqErr <= 1'b1;
      end
    end
  end

  assign statusByte = {ready, 1'b0, seqErr, pgmErr, 1'b0, suspended, 2'b00};

  always_comb begin
    case (32'(rdAddr))
      32'h00:  identByte = MFR_CODE;
      32'h01:  identByte = DEV_CODE;
      default: identByte = 8'h00;
    endcase
    case (32'(rdAddr))
      32'h10:  queryByte = 8'h51;
      32'h11:  queryByte = 8'h52;
      32'h12:  queryByte = 8'h59;
      32'h27:  queryByte = ARRAY_LOG;
      32'h2A:  queryByte = BUF_LOG;
      default: queryByte = 8'h00;
    endcase
    unique case (readMode)
      RM_ARRAY:  rdData = mem[rdAddr];
      RM_STATUS: rdData = {8'h00, statusByte};
      RM_IDENT:  rdData = {8'h00, identByte};
      RM_QUERY:  rdData = {8'h00, queryByte};
      default:   rdData = '0;
    endcase
  end

  // R7: nothing raises or clears an error while an operation is busy
  a_r7_busy_errs_frozen: assert property (@(posedge clk) disable iff (!rstN)
    !ready |=> ($stable(pgmErr) && $stable(seqErr)));

  // R10: an aborted sequence writes nothing into the array
  a_r10_abort_no_write: assert property (@(posedge clk) disable iff (!rstN)
    stb.setPgmErr |-> !(stb.commitWord || stb.commitBuf || stb.directWrite));

  // R6: at most one array write path is active per cycle
  a_r6_one_writer: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.commitWord, stb.commitBuf, stb.directWrite}));

  // R13: a flagged sequence error is visible on the next cycle
  a_r13_seq_err_set: assert property (@(posedge clk) disable iff (!rstN)
    (stb.setSeqErr && !stb.clrErr) |=> seqErr);

endmodule

// File: rtl/flash_cmd_ui.sv
module flash_cmd_ui
  import flash_cmd_pkg::*;
#(
  parameter int         ADDR_W      = 6,
  parameter int         BUF_DEPTH   = 512,
  parameter int         BUSY_CYCLES = 8,
  parameter logic [7:0] MFR_CODE    = 8'hC3,
  parameter logic [7:0] DEV_CODE    = 8'h5E
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [15:0]       wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [15:0]       rdData
);

  localparam int CNT_W = $clog2(BUF_DEPTH);

  dpStrobe_t        stb;
  logic [CNT_W-1:0] bufIdx;
  readMode_t        readMode;
  logic             ready, suspended;

  flash_cmd_ctrl #(.BUF_DEPTH(BUF_DEPTH), .BUSY_CYCLES(BUSY_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .stb(stb), .bufIdx(bufIdx), .readMode(readMode),
    .ready(ready), .suspended(suspended)
  );

  flash_cmd_dpath #(.ADDR_W(ADDR_W), .BUF_DEPTH(BUF_DEPTH),
                    .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) uDpath (
    .clk(clk), .rstN(rstN), .stb(stb), .bufIdx(bufIdx),
    .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr),
    .readMode(readMode), .ready(ready), .suspended(suspended),
    .rdData(rdData)
  );

endmodule

// File: tb/tb_flash_cmd_ui.sv
`timescale 1ns/1ps
module tb_flash_cmd_ui;

  localparam int ADDR_W = 6;
  localparam int BUSY   = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrEn = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [15:0]       wrData = '0;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic [15:0]       rdData;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  flash_cmd_ui #(.ADDR_W(ADDR_W), .BUF_DEPTH(512), .BUSY_CYCLES(BUSY),
                 .MFR_CODE(8'hC3), .DEV_CODE(8'h5E)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [15:0] d);
    rdAddr = a;
    #1;
    d = rdData;
  endtask

  // counts cycles until status bit 7 rises (status mode must be active)
  task automatic waitReady(output int cyc);
    logic [15:0] v;
    cyc = 0;
    rd('0, v);
    while (!v[7] && cyc < 2000) begin
      @(negedge clk);
      cyc++;
      rd('0, v);
    end
  endtask

  task automatic tReset();
    logic [15:0] v;
    rd(6'd0, v);  check("R1 array word 0", v, 16'hFFFF);
    rd(6'd63, v); check("R1 array word 63", v, 16'hFFFF);
    wr(0, 16'h0070);
    rd(0, v);     check("R1 status after reset", v, 16'h0080);
  endtask

  task automatic tReadModes();
    logic [15:0] v;
    wr(0, 16'h0090);
    rd(0, v);  check("R4 ident mfr", v, 16'h00C3);
    rd(1, v);  check("R4 ident dev", v, 16'h005E);
    rd(2, v);  check("R4 ident other", v, 16'h0000);
    wr(0, 16'h0098);
    rd(6'h10, v); check("R4 query Q", v, 16'h0051);
    rd(6'h11, v); check("R4 query R", v, 16'h0052);
    rd(6'h12, v); check("R4 query Y", v, 16'h0059);
    rd(6'h27, v); check("R4 query array size", v, 16'h0007);
    rd(6'h2A, v); check("R4 query buffer size", v, 16'h000A);
    wr(0, 16'h0070);
    rd(9, v);  check("R3 status upper byte zero", v, 16'h0080);
    wr(0, 16'h00FF);
    rd(9, v);  check("R2 array read", v, 16'hFFFF);
  endtask

  task automatic tErrors();
    logic [15:0] v;
    wr(0, 16'h0070);
    wr(0, 16'h0012);
    rd(0, v);  check("R13 unknown opcode gives array mode", v, 16'hFFFF);
    wr(0, 16'h0070);
    rd(0, v);  check("R13 seq error bit 5", v, 16'h00A0);
    wr(0, 16'h0050);
    rd(0, v);  check("R5 clear keeps status mode", v, 16'h0080);
  endtask

  task automatic tProgram();
    logic [15:0] v;
    int cyc;
    wr(0, 16'h0040);
    wr(5, 16'hA5F0);
    rd(0, v);  check("R6 busy status", v, 16'h0000);
    waitReady(cyc);
    check("R6 busy length", 16'(cyc), 16'(BUSY));
    rd(5, v);  check("R6 still status mode", v, 16'h0080);
    wr(0, 16'h00FF);
    rd(5, v);  check("R6 word programmed", v, 16'hA5F0);
    wr(0, 16'h0040);
    wr(5, 16'h0FFF);
    waitReady(cyc);
    wr(0, 16'h00FF);
    rd(5, v);  check("R6 AND merge", v, 16'h05F0);
  endtask

  task automatic tBusyIgnore();
    logic [15:0] v;
    int cyc;
    wr(0, 16'h0040);
    wr(7, 16'h00F0);
    wr(0, 16'h00FF);
    rd(7, v);  check("R7 FF ignored while busy", v, 16'h0000);
    wr(0, 16'h0012);
    wr(7, 16'h0040);
    waitReady(cyc);
    rd(0, v);  check("R7 no error from busy writes", v, 16'h0080);
    wr(0, 16'h00FF);
    rd(7, v);  check("R7 only programmed data", v, 16'h00F0);
  endtask

  task automatic tSuspend();
    logic [15:0] v;
    int cyc;
    wr(0, 16'h0040);
    wr(9, 16'h1234);
    repeat (2) @(negedge clk);
    wr(0, 16'h00B0);
    rd(0, v);  check("R8 suspended status", v, 16'h0084);
    wr(0, 16'h00FF);
    rd(9, v);  check("R8 array unchanged while suspended", v, 16'hFFFF);
    wr(0, 16'h0050);
    wr(0, 16'h00D0);
    rd(0, v);  check("R8 resumed busy", v, 16'h0000);
    waitReady(cyc);
    wr(0, 16'h00FF);
    rd(9, v);  check("R8 program completes", v, 16'h1234);
  endtask

  task automatic tBuffered();
    logic [15:0] v;
    int cyc;
    wr(0, 16'h00E8);
    wr(0, 16'h0002);
    wr(10, 16'h1111);
    wr(11, 16'h2222);
    wr(12, 16'h3333);
    rd(10, v); check("R9 status before confirm", v, 16'h0080);
    wr(0, 16'h00D0);
    waitReady(cyc);
    check("R9 busy length", 16'(cyc), 16'(BUSY + 3));
    wr(0, 16'h00FF);
    rd(10, v); check("R9 word 0", v, 16'h1111);
    rd(11, v); check("R9 word 1", v, 16'h2222);
    rd(12, v); check("R9 word 2", v, 16'h3333);
  endtask

  task automatic tBufAbort();
    logic [15:0] v;
    wr(0, 16'h00E8);
    wr(0, 16'd600);
    rd(0, v);  check("R10 count too large", v, 16'h0090);
    wr(0, 16'h0050);
    wr(0, 16'h00E8);
    wr(0, 16'h0000);
    wr(20, 16'h0000);
    wr(0, 16'h0077);
    rd(0, v);  check("R10 bad confirm", v, 16'h0090);
    wr(0, 16'h00FF);
    rd(20, v); check("R10 array untouched", v, 16'hFFFF);
    wr(0, 16'h0050);
  endtask

  task automatic tFactoryBad();
    logic [15:0] v;
    wr(0, 16'h0080);
    wr(0, 16'h0012);
    rd(0, v);  check("R12 bad factory confirm", v, 16'h00A0);
    wr(0, 16'h0050);
    rd(0, v);  check("R12 decoder accepts new command", v, 16'h0080);
  endtask

  task automatic tFactory();
    logic [15:0] v;
    wr(0, 16'h0080);
    wr(0, 16'h00D0);
    rd(30, v); check("R11 array reads in factory", v, 16'hFFFF);
    wr(30, 16'h00FF);
    wr(31, 16'h0050);
    wr(32, 16'h0070);
    rd(30, v); check("R11 data 0xFF programmed", v, 16'h00FF);
    rd(31, v); check("R11 data 0x50 programmed", v, 16'h0050);
    rd(32, v); check("R11 0x70 not decoded", v, 16'h0070);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tReadModes();
    tErrors();
    tProgram();
    tBusyIgnore();
    tSuspend();
    tBuffered();
    tBufAbort();
    tFactoryBad();
    tFactory();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule